// File: doc/BRIEF.md
# DMA Interrupt Status Word

This block keeps the interrupt status word of a descriptor-driven Ethernet DMA engine and drives the single interrupt line to the host. The transmit and receive DMA paths report events as one-cycle pulses. Each pulse sets its own sticky status bit, and software later clears that bit by writing a 1 to its position. A separate interrupt-enable word, supplied as an input, decides which latched events feed the two summary bits. The normal summary covers completion-type events and the abnormal summary covers error-type events.

The word also carries several read-only fields that software inspects while it handles an interrupt:
- the live state codes of the transmit and receive DMA state machines,
- a three-bit bus-error type, shown only while the fatal-bus-error bit is set,
- four level flags from MAC sub-blocks: low-power idle, timestamp, statistics counters and line status.

Any raised summary bit or any high sub-block flag drives the interrupt output. Both the status word and the interrupt output are registered.

Top module: `dma_irq_status`

## Requirements
- R1: A pulse on `evt_pulse[i]` for i in 0..10, 13 or 14 sets status bit i. The bit stays set until software clears it, and it appears on `status_word` two clock edges after the pulse is driven.
- R2: When `wr_en` is high, each 1 in `wr_data[16:0]` clears the status bit at the same position and each 0 leaves its bit unchanged. When `wr_en` is low, `wr_data` has no effect.
- R3: The normal summary, bit 16, sets when `ien[16]` is high and at least one of the status bits 0, 2, 6 or 14 is set while its own `ien` bit is high.
- R4: The abnormal summary, bit 15, sets when `ien[15]` is high and at least one of the status bits 1, 3, 4, 5, 7, 8, 9, 10 or 13 is set while its own `ien` bit is high.
- R5: An event whose `ien` bit is low still sets its status bit, but it does not feed either summary bit.
- R6: A summary bit stays set after its contributing bits have been cleared. It clears only when software writes a 1 to it. A single write that clears the summary bit together with all of its contributors leaves it at 0.
- R7: A receive-complete pulse (bit 6) clears the early-receive bit 14. This also holds when an early-receive pulse arrives in the same cycle.
- R8: When a set pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R9: Bits 25:23 show `bus_err_type` while status bit 13 is set and read 0 otherwise. Within this field, bit 23 = 1 means Tx DMA, bit 24 = 1 means a read, and bit 25 = 1 means a descriptor access.
- R10: Bits 22:20 copy `tx_state` and bits 19:17 copy `rx_state`, one clock edge after the input. Neither field affects `irq`.
- R11: `sub_lvl[0..3]` appear at bits 30, 29, 27 and 26, one edge after the input. Writes do not change them. While any of them is high, `irq` goes high one edge later.
- R12: `irq` is the registered OR of the two summary bits and the four sub-block levels. A latched event that feeds neither summary bit leaves `irq` low.
- R13: Bits 31, 28, 12 and 11 always read 0, and pulses on `evt_pulse[11]` and `evt_pulse[12]` are ignored. A synchronous reset clears every latched bit, `status_word` and `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 15 | Per-event set pulses, indexed by status bit position |
| wr_en | input | 1 | Write strobe for the write-1-clear port |
| wr_data | input | 17 | Clear mask for status bits 16..0 |
| ien | input | 17 | Interrupt-enable word for bits 16..0 |
| bus_err_type | input | 3 | Bus-error type from the DMA bus interface |
| tx_state | input | 3 | Transmit DMA state code |
| rx_state | input | 3 | Receive DMA state code |
| sub_lvl | input | 4 | Sub-block interrupt levels: LPI, timestamp, counters, line |
| status_word | output | 32 | Registered status word |
| irq | output | 1 | Registered host interrupt |

## Verification
Results arrive with two different latencies:
- **Two edges.** A pulse or a write updates the latched bits and the summary bits on the first edge. `status_word` and `irq` follow on the second edge.
- **One edge.** State codes, the bus-error type (once bit 13 is already set) and the sub-block levels reach `status_word` and `irq` after a single edge.

The bench drives every input on a falling edge. For pulses and writes, it holds the stimulus for one cycle, removes it, and samples on the next falling edge, which comes after both registering edges. For the read-only inputs, it samples on the falling edge after one rising edge.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned STAT_W  = 32;
  localparam int unsigned EVT_W   = 15;
  localparam int unsigned CLR_W   = 17;
  localparam int unsigned ST_W    = 3;
  localparam int unsigned ERR_W   = 3;
  localparam int unsigned SUB_N   = 4;

  localparam int unsigned AIS_POS    = 15;
  localparam int unsigned NIS_POS    = 16;
  localparam int unsigned RX_ST_LSB  = 17;
  localparam int unsigned TX_ST_LSB  = 20;
  localparam int unsigned ERR_LSB    = 23;
  localparam int unsigned FBI_POS    = 13;
  localparam int unsigned RCV_POS    = 6;
  localparam int unsigned ERCV_POS   = 14;
  localparam int unsigned SUB_POS [SUB_N] = '{30, 29, 27, 26};

  localparam logic [EVT_W-1:0] LIVE_MASK = 15'h67FF;
  localparam logic [EVT_W-1:0] NORM_MASK = 15'h4045;
  localparam logic [EVT_W-1:0] ABN_MASK  = 15'h27BA;

  typedef struct packed {
    logic [ERR_W-1:0] err_type;
    logic [ST_W-1:0]  tx_st;
    logic [ST_W-1:0]  rx_st;
    logic [SUB_N-1:0] sub;
  } ro_fields_t;
endpackage

// File: rtl/irq_event_bank.sv
module irq_event_bank
  import dma_irq_pkg::*;
#(
  parameter int unsigned     W        = EVT_W,
  parameter logic [W-1:0]    LIVE     = LIVE_MASK,
  parameter int unsigned     SRC_POS  = RCV_POS,
  parameter int unsigned     DST_POS  = ERCV_POS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_pulse,
  input  logic         wr_en,
  input  logic [W-1:0] wr_clr,
  output logic [W-1:0] bits_q,
  output logic [W-1:0] bits_nxt
);
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;
  logic         unused_rsvd;

  assign set_v = evt_pulse & LIVE;
  assign clr_v = wr_clr & {W{wr_en}};
  assign unused_rsvd = ^((evt_pulse | wr_clr) & ~LIVE);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (!LIVE[i]) begin : g_rsvd
      assign bits_nxt[i] = 1'b0;
    end else if (i == DST_POS) begin : g_auto
      assign bits_nxt[i] = ((bits_q[i] & ~clr_v[i]) | set_v[i]) & ~set_v[SRC_POS];
    end else begin : g_plain
      assign bits_nxt[i] = (bits_q[i] & ~clr_v[i]) | set_v[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else     bits_q <= bits_nxt;
  end

  localparam logic [W-1:0] SET_CHK = LIVE & ~(W'(1) << DST_POS);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    |(evt_pulse & SET_CHK) |=> ((bits_q & $past(evt_pulse & SET_CHK)) == $past(evt_pulse & SET_CHK))); // R8
  AST_ERCV_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
    evt_pulse[SRC_POS] |=> !bits_q[DST_POS]); // R7
  AST_WR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_clr[0] && !evt_pulse[0]) |=> !bits_q[0]); // R2
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import dma_irq_pkg::*;
#(
  parameter int unsigned  W      = EVT_W,
  parameter logic [W-1:0] CONTRIB = NORM_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bits_nxt,
  input  logic [W-1:0] ien_evt,
  input  logic         ien_sum,
  input  logic         clr,
  output logic         sum_q
);
  logic hit;
  logic sum_d;

  assign hit   = ien_sum & |(bits_nxt & ien_evt & CONTRIB);
  assign sum_d = hit | (sum_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) sum_q <= 1'b0;
    else     sum_q <= sum_d;
  end

  AST_SUM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sum_q && !clr) |=> sum_q); // R6
  AST_SUM_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!ien_sum && !sum_q) |=> !sum_q); // R5
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import dma_irq_pkg::*;
#(
  parameter int unsigned W  = EVT_W,
  parameter int unsigned SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  bits_q,
  input  logic          nis_q,
  input  logic          ais_q,
  input  ro_fields_t    ro,
  output logic [SW-1:0] status_word,
  output logic          irq
);
  logic [SW-1:0] word_d;
  logic          irq_d;

  always_comb begin
    word_d = '0;
    word_d[W-1:0] = bits_q & LIVE_MASK;
    word_d[AIS_POS] = ais_q;
    word_d[NIS_POS] = nis_q;
    word_d[RX_ST_LSB +: ST_W] = ro.rx_st;
    word_d[TX_ST_LSB +: ST_W] = ro.tx_st;
    word_d[ERR_LSB +: ERR_W]  = bits_q[FBI_POS] ? ro.err_type : '0;
    for (int k = 0; k < SUB_N; k++) word_d[SUB_POS[k]] = ro.sub[k];
  end

  assign irq_d = nis_q | ais_q | (|ro.sub);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_word <= '0;
      irq         <= 1'b0;
    end else begin
      status_word <= word_d;
      irq         <= irq_d;
    end
  end

  AST_SUB_IRQ: assert property (@(posedge clk) disable iff (rst)
    (|ro.sub) |=> irq); // R11
  AST_ERR_GATED: assert property (@(posedge clk) disable iff (rst)
    !bits_q[FBI_POS] |=> (status_word[ERR_LSB +: ERR_W] == '0)); // R9
  AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!nis_q && !ais_q && !(|ro.sub)) |=> !irq); // R12
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic              wr_en,
  input  logic [CLR_W-1:0]  wr_data,
  input  logic [CLR_W-1:0]  ien,
  input  logic [ERR_W-1:0]  bus_err_type,
  input  logic [ST_W-1:0]   tx_state,
  input  logic [ST_W-1:0]   rx_state,
  input  logic [SUB_N-1:0]  sub_lvl,
  output logic [STAT_W-1:0] status_word,
  output logic              irq
);
  logic [EVT_W-1:0] bits_q;
  logic [EVT_W-1:0] bits_nxt;
  logic             nis_q;
  logic             ais_q;
  ro_fields_t       ro;

  assign ro.err_type = bus_err_type;
  assign ro.tx_st    = tx_state;
  assign ro.rx_st    = rx_state;
  assign ro.sub      = sub_lvl;

  irq_event_bank #(.W(EVT_W), .LIVE(LIVE_MASK), .SRC_POS(RCV_POS), .DST_POS(ERCV_POS)) u_bank (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .wr_en(wr_en),
    .wr_clr(wr_data[EVT_W-1:0]), .bits_q(bits_q), .bits_nxt(bits_nxt)
  );

  irq_summary #(.W(EVT_W), .CONTRIB(NORM_MASK)) u_norm (
    .clk(clk), .rst(rst), .bits_nxt(bits_nxt), .ien_evt(ien[EVT_W-1:0]),
    .ien_sum(ien[NIS_POS]), .clr(wr_en & wr_data[NIS_POS]), .sum_q(nis_q)
  );

  irq_summary #(.W(EVT_W), .CONTRIB(ABN_MASK)) u_abn (
    .clk(clk), .rst(rst), .bits_nxt(bits_nxt), .ien_evt(ien[EVT_W-1:0]),
    .ien_sum(ien[AIS_POS]), .clr(wr_en & wr_data[AIS_POS]), .sum_q(ais_q)
  );

  irq_readback #(.W(EVT_W), .SW(STAT_W)) u_rb (
    .clk(clk), .rst(rst), .bits_q(bits_q), .nis_q(nis_q), .ais_q(ais_q),
    .ro(ro), .status_word(status_word), .irq(irq)
  );

  AST_RSVD_PULSE: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse[11] || evt_pulse[12]) |=> (bits_q[12:11] == 2'b00)); // R13
  AST_NO_WR_NO_CLR: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && bits_q[1]) |=> bits_q[1]); // R2
endmodule

// File: tb/test_dma_irq_status.sv
`timescale 1ns/1ps
module test_dma_irq_status;
  localparam logic [16:0] NORM = 17'h04045;
  localparam logic [16:0] ABN  = 17'h027BA;
  localparam logic [14:0] LIVE = 15'h67FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] evt_pulse = '0;
  logic        wr_en = 1'b0;
  logic [16:0] wr_data = '0;
  logic [16:0] ien = '0;
  logic [2:0]  bus_err_type = '0;
  logic [2:0]  tx_state = '0;
  logic [2:0]  rx_state = '0;
  logic [3:0]  sub_lvl = '0;
  logic [31:0] status_word;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  dma_irq_status i_dma_irq_status (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .wr_en(wr_en), .wr_data(wr_data),
    .ien(ien), .bus_err_type(bus_err_type), .tx_state(tx_state), .rx_state(rx_state),
    .sub_lvl(sub_lvl), .status_word(status_word), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [14:0] p);
    evt_pulse = p; tick(); evt_pulse = '0; tick();
  endtask

  task automatic wr(input logic [16:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R13 reset word", status_word, 32'h0);
    chk("R13 reset irq", {31'h0, irq}, 32'h0);

    // Sweep every event position under three enable patterns
    bus_err_type = 3'b101;
    for (int i = 0; i < 15; i++) begin
      for (int m = 0; m < 3; m++) begin
        logic live, nis_e, ais_e;
        string tag;
        ien = (m == 0) ? 17'h1FFFF : (m == 1) ? (17'h1FFFF & ~(17'd1 << i)) : 17'h07FFF;
        pulse(15'd1 << i);
        live  = LIVE[i];
        nis_e = live && NORM[i] && ien[i] && ien[16];
        ais_e = live && ABN[i]  && ien[i] && ien[15];
        exp = '0;
        exp[i] = live;
        exp[16] = nis_e;
        exp[15] = ais_e;
        if (live && i == 13) exp[25:23] = 3'b101;
        tag = !live ? "R13 rsvd pulse" : (m == 1 ? "R5 masked" : "R1/R3/R4/R9 set");
        chk(tag, status_word, exp);
        chk("R12 irq", {31'h0, irq}, {31'h0, nis_e | ais_e});
        wr(17'h1FFFF);
        chk("R2/R9 clear all", status_word, 32'h0);
        chk("R12 irq after clear", {31'h0, irq}, 32'h0);
      end
    end
    bus_err_type = 3'b000;

    // R2: zeros leave bits, strobe low ignored
    ien = 17'h0;
    pulse(15'h0003);
    wr(17'h00001);
    chk("R2 partial clear", status_word, 32'h2);
    wr_data = 17'h1FFFF; tick(); tick(); wr_data = '0;
    chk("R2 no strobe", status_word, 32'h2);
    wr(17'h1FFFF);

    // R6: sticky summary
    ien = 17'h10001;
    pulse(15'h0001);
    chk("R6 set", status_word, 32'h10001);
    wr(17'h00001);
    chk("R6 sticky", status_word, 32'h10000);
    chk("R6 sticky irq", {31'h0, irq}, 32'h1);
    wr(17'h10000);
    chk("R6 cleared", status_word, 32'h0);
    pulse(15'h0001);
    wr(17'h10001);
    chk("R6 joint clear", status_word, 32'h0);
    ien = 17'h0;

    // R7: early receive auto-clear
    pulse(15'h4000);
    chk("R7 early set", status_word, 32'h4000);
    pulse(15'h0040);
    chk("R7 auto clear", status_word, 32'h0040);
    pulse(15'h4040);
    chk("R7 same cycle", status_word, 32'h0040);
    wr(17'h1FFFF);

    // R8: set beats clear
    pulse(15'h0008);
    evt_pulse = 15'h0008; wr_en = 1'b1; wr_data = 17'h00008; tick();
    evt_pulse = '0; wr_en = 1'b0; wr_data = '0; tick();
    chk("R8 set wins", status_word, 32'h0008);
    wr(17'h1FFFF);

    // R9: error type follows input while bit 13 held
    pulse(15'h2000);
    for (int e = 0; e < 8; e++) begin
      bus_err_type = 3'(e); tick();
      chk("R9 err field", status_word, 32'h2000 | (32'(e) << 23));
    end
    wr(17'h1FFFF);
    chk("R9 gated", status_word, 32'h0);
    bus_err_type = '0;

    // R10: state codes
    for (int s = 0; s < 8; s++) begin
      tx_state = 3'(s); rx_state = 3'(7 - s); tick();
      chk("R10 states", status_word, (32'(s) << 20) | (32'(7 - s) << 17));
      chk("R10 no irq", {31'h0, irq}, 32'h0);
    end
    tx_state = '0; rx_state = '0; tick();

    // R11: sub-block levels
    for (int k = 0; k < 4; k++) begin
      int pos;
      pos = (k == 0) ? 30 : (k == 1) ? 29 : (k == 2) ? 27 : 26;
      sub_lvl = 4'(1 << k); tick();
      chk("R11 level bit", status_word, 32'h1 << pos);
      chk("R11 irq", {31'h0, irq}, 32'h1);
      wr(17'h1FFFF);
      chk("R11 write ignored", status_word, 32'h1 << pos);
      sub_lvl = '0; tick();
      chk("R11 level drop", {31'h0, irq}, 32'h0);
    end

    // R13: reset mid-run
    ien = 17'h1FFFF;
    pulse(15'h0021);
    rst = 1'b1; tick(); rst = 1'b0; tick();
    chk("R13 reset word", status_word, 32'h0);
    chk("R13 reset irq", {31'h0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule